// File: doc/BRIEF.md
# Dual-Lane Fractional Multiply-Saturate Unit

This block is a 64-bit SIMD multiply stage. Each operand is treated as two 32-bit lanes: the high lane is bits 63:32 and the low lane is bits 31:0. Each lane forms a signed fractional (Q-format) product, so the raw product is doubled. The product is either 16x16, taken from the upper or the lower halfword of each lane, or 32x32, taken from the full lane word. A wide mode is also available. It multiplies the two low-lane words into one 64-bit doubled product, and that product fills the whole result.

Each lane product is held as a 64-bit signed intermediate value. The block checks this value against a signed or an unsigned 32-bit range. When the value is out of range and saturation is enabled, the lane takes a limit value, chosen by the sign of the intermediate. The result, the per-lane overflow flags and an optional write to a 64-bit accumulator are all registered. They appear one clock after the operands are applied.

Top module: `dual_frac_mac`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `result`, `acc_out`, `ovf_hi` and `ovf_lo` become zero.
- R2: With `op_sel[1:0]`=00 (upper halfwords), each lane's intermediate value is the signed product of bits 31:16 of the two lane words, multiplied by two. When no saturation applies, the lane result is the low 32 bits of that value.
- R3: With `op_sel[1:0]`=01 (lower halfwords), the lane behaves as in R2, but uses bits 15:0 of each lane word.
- R4: With `op_sel[1:0]`=10 (full word), each lane's intermediate value is the signed 64-bit product of the two lane words, arithmetically shifted right by 31. When no saturation applies, the lane result is its low 32 bits. The MSB of the product is not lost.
- R5: With `op_sel[2]`=0, a lane flags overflow when its intermediate value is below -2^31 or above 2^31-1. The flag does not depend on `sat_en`. When `sat_en`=1, the lane result becomes 0x80000000 if the intermediate value is negative, and 0x7FFFFFFF otherwise.
- R6: With `op_sel[2]`=1, a lane flags overflow when its intermediate value is negative or above 0xFFFFFFFF. When `sat_en`=1, the lane result becomes 0x00000000 if the intermediate value is negative, and 0xFFFFFFFF otherwise.
- R7: With `op_sel[1:0]`=11 (wide), `result` is the signed product of the two low-lane words shifted left by one. This shift wraps. `ovf_lo` flags the case where the shift changes the sign, and with `sat_en`=1 that case gives 0x7FFFFFFFFFFFFFFF. In this mode `ovf_hi` is 0 and `op_sel[2]` has no effect.
- R8: When `acc_wr`=1, `acc_out` loads the same 64-bit value that `result` takes, at the same edge. When `acc_wr`=0, `acc_out` holds its value.
- R9: `result`, `ovf_hi` and `ovf_lo` reflect the operands sampled at the previous rising edge. A flag lasts only for the cycle of the operation that raised it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | 64 | Operand A, two 32-bit lanes |
| op_b | input | 64 | Operand B, two 32-bit lanes |
| op_sel | input | 3 | [1:0] product mode, [2] unsigned saturation range |
| sat_en | input | 1 | Replace overflowing results with limit values |
| acc_wr | input | 1 | Load the accumulator with this operation's result |
| result | output | 64 | Registered result, high lane in 63:32 |
| acc_out | output | 64 | Accumulator contents |
| ovf_hi | output | 1 | High-lane overflow, one cycle |
| ovf_lo | output | 1 | Low-lane or wide overflow, one cycle |

## Verification
Each product mode is driven with operands whose halfwords and words all differ between the two lanes. A mode that picks the wrong halfword, lane or shift therefore produces a visibly different result. Sign-mixed operands and the most-negative-times-most-negative case are applied with saturation on and off. This separates the flag from the clamp, and it exposes the top-sign-bit loss of the doubled product. The unsigned range is tried with negative products, and the wide mode is tried with both op_sel[2] values. Accumulator writes alternate with held cycles and a mid-run reset, and a clean operation is applied right after an overflowing one to confirm that the flags drop.

// File: rtl/fmac_pkg.sv
// Shared types for the dual-lane fractional multiply-saturate unit.
// Assumes op_sel[1:0] carries the product mode in the encoding below.
package fmac_pkg;

    typedef enum logic [1:0] {
        MODE_HIHALF = 2'b00,
        MODE_LOHALF = 2'b01,
        MODE_WORD   = 2'b10,
        MODE_WIDE   = 2'b11
    } fmac_mode_e;

endpackage

// File: rtl/frac_lane_mul.sv
// One lane's fractional multiplier. It builds the 2*LANE_W-bit signed
// intermediate value for the halfword or word modes, and it also provides
// the exact full-word product for the wide path.
// Assumes LANE_W is even.
module frac_lane_mul
    import fmac_pkg::*;
#(
    parameter int LANE_W = 32
) (
    input  logic [LANE_W-1:0]   a_i,
    input  logic [LANE_W-1:0]   b_i,
    input  fmac_mode_e          mode_i,
    output logic [2*LANE_W-1:0] inter_o,
    output logic [2*LANE_W-1:0] exact_o
);
    localparam int HW = LANE_W / 2;
    localparam int PW = 2 * LANE_W;

    logic signed [HW-1:0]     half_a;
    logic signed [HW-1:0]     half_b;
    logic signed [LANE_W-1:0] half_prod;
    logic signed [PW-1:0]     half_ext;
    logic signed [PW-1:0]     word_prod;

    // Pick the halfword pair named by the mode.
    always_comb begin
        if (mode_i == MODE_HIHALF) begin
            half_a = a_i[LANE_W-1:HW];
            half_b = b_i[LANE_W-1:HW];
        end else begin
            half_a = a_i[HW-1:0];
            half_b = b_i[HW-1:0];
        end
    end

    // Form the signed products. The halfword product fits LANE_W bits exactly.
    always_comb begin
        half_prod = half_a * half_b;
        half_ext  = {{(PW-LANE_W){half_prod[LANE_W-1]}}, half_prod};
        word_prod = $signed(a_i) * $signed(b_i);
    end

    // Scale to the common Q(LANE_W-1) intermediate without losing the sign bit.
    always_comb begin
        if (mode_i == MODE_HIHALF || mode_i == MODE_LOHALF) begin
            inter_o = half_ext <<< 1;
        end else begin
            inter_o = word_prod >>> (LANE_W - 1);
        end
        exact_o = word_prod;
    end

endmodule

// File: rtl/lane_saturate.sv
// One lane's range check and clamp. It tests the signed intermediate value
// against the signed or unsigned LANE_W-bit range, and it picks the limit
// value from the sign of the intermediate.
// Assumes the intermediate is two's complement, 2*LANE_W bits wide.
module lane_saturate #(
    parameter int LANE_W = 32
) (
    input  logic [2*LANE_W-1:0] inter_i,
    input  logic                uns_i,
    input  logic                sat_en_i,
    output logic [LANE_W-1:0]   res_o,
    output logic                ovf_o
);
    localparam int PW = 2 * LANE_W;

    logic              neg;
    logic              ovf_s;
    logic              ovf_u;
    logic [LANE_W-1:0] limit;

    // Detect an out-of-range intermediate for each range kind.
    always_comb begin
        neg   = inter_i[PW-1];
        ovf_s = !((&inter_i[PW-1:LANE_W-1]) || !(|inter_i[PW-1:LANE_W-1]));
        ovf_u = |inter_i[PW-1:LANE_W];
        ovf_o = uns_i ? ovf_u : ovf_s;
    end

    // Choose the clamp value by range kind and sign.
    always_comb begin
        if (uns_i) begin
            limit = neg ? '0 : '1;
        end else begin
            limit = neg ? {1'b1, {(LANE_W-1){1'b0}}} : {1'b0, {(LANE_W-1){1'b1}}};
        end
    end

    // Pass the low lane bits, or the limit when clamping.
    always_comb begin
        res_o = (ovf_o && sat_en_i) ? limit : inter_i[LANE_W-1:0];
    end

endmodule

// File: rtl/fmac_acc.sv
// The accumulator register. It loads the full result word when the write
// enable is high and holds otherwise. Synchronous active-low reset to zero.
module fmac_acc #(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [DW-1:0] d_i,
    output logic [DW-1:0] q_o
);
    // Keep the accumulator value, or load it on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= '0;
        end else if (wr_i) begin
            q_o <= d_i;
        end
    end

endmodule

// File: rtl/dual_frac_mac.sv
// Dual-lane fractional multiply-saturate top. Two lane multipliers and two
// lane clamps cover the halfword and word modes. A wide path uses the
// low-lane exact product. Result, flags and accumulator are registered, so
// everything appears one cycle after the operands.
// Assumes operands are stable around the rising edge; synchronous active-low reset.
module dual_frac_mac
    import fmac_pkg::*;
#(
    parameter int LANE_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*LANE_W-1:0] op_a,
    input  logic [2*LANE_W-1:0] op_b,
    input  logic [2:0]          op_sel,
    input  logic                sat_en,
    input  logic                acc_wr,
    output logic [2*LANE_W-1:0] result,
    output logic [2*LANE_W-1:0] acc_out,
    output logic                ovf_hi,
    output logic                ovf_lo
);
    localparam int DW    = 2 * LANE_W;
    localparam int LANES = DW / LANE_W;

    fmac_mode_e        mode;
    logic [DW-1:0]     lane_inter [LANES];
    logic [DW-1:0]     lane_exact [LANES];
    logic [LANE_W-1:0] lane_res   [LANES];
    logic              lane_ovf   [LANES];

    logic [DW-1:0]     wide_dbl;
    logic              wide_ovf;
    logic [DW-1:0]     wide_res;
    logic [DW-1:0]     next_res;
    logic              next_ovf_hi;
    logic              next_ovf_lo;

    // Decode the product mode from the select field.
    always_comb begin
        mode = fmac_mode_e'(op_sel[1:0]);
    end

    // One multiplier and one clamp per lane.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        frac_lane_mul #(.LANE_W(LANE_W)) u_mul (
            .a_i     (op_a[l*LANE_W +: LANE_W]),
            .b_i     (op_b[l*LANE_W +: LANE_W]),
            .mode_i  (mode),
            .inter_o (lane_inter[l]),
            .exact_o (lane_exact[l])
        );
        lane_saturate #(.LANE_W(LANE_W)) u_sat (
            .inter_i  (lane_inter[l]),
            .uns_i    (op_sel[2]),
            .sat_en_i (sat_en),
            .res_o    (lane_res[l]),
            .ovf_o    (lane_ovf[l])
        );
    end

    // Wide path: double the low-lane product; overflow if the doubling flips the sign.
    always_comb begin
        wide_dbl = lane_exact[0] << 1;
        wide_ovf = lane_exact[0][DW-1] ^ lane_exact[0][DW-2];
        if (wide_ovf && sat_en) begin
            wide_res = lane_exact[0][DW-1] ? {1'b1, {(DW-1){1'b0}}}
                                           : {1'b0, {(DW-1){1'b1}}};
        end else begin
            wide_res = wide_dbl;
        end
    end

    // Merge the lane results or take the wide result.
    always_comb begin
        if (mode == MODE_WIDE) begin
            next_res    = wide_res;
            next_ovf_hi = 1'b0;
            next_ovf_lo = wide_ovf;
        end else begin
            next_res    = {lane_res[1], lane_res[0]};
            next_ovf_hi = lane_ovf[1];
            next_ovf_lo = lane_ovf[0];
        end
    end

    // Register the result and the single-cycle flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            ovf_hi <= 1'b0;
            ovf_lo <= 1'b0;
        end else begin
            result <= next_res;
            ovf_hi <= next_ovf_hi;
            ovf_lo <= next_ovf_lo;
        end
    end

    fmac_acc #(.DW(DW)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_i  (acc_wr),
        .d_i   (next_res),
        .q_o   (acc_out)
    );

endmodule

// File: rtl/fmac_checker.sv
// Temporal checks on the dual-lane fractional multiply-saturate unit,
// attached to every instance of the top module by bind.
module fmac_checker #(
    parameter int DW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    op_sel,
    input logic          sat_en,
    input logic          acc_wr,
    input logic [DW-1:0] result,
    input logic [DW-1:0] acc_out,
    input logic          ovf_hi,
    input logic          ovf_lo
);
    localparam int LW = DW / 2;
    localparam logic [LW-1:0] SMAX = {1'b0, {(LW-1){1'b1}}};
    localparam logic [LW-1:0] SMIN = {1'b1, {(LW-1){1'b0}}};

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (result == '0 && acc_out == '0 && !ovf_hi && !ovf_lo));

    assert_signed_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_en && !op_sel[2] && op_sel[1:0] != 2'b11)
        |=> (!ovf_hi || result[DW-1:LW] == SMAX || result[DW-1:LW] == SMIN));

    assert_unsigned_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_en && op_sel[2] && op_sel[1:0] != 2'b11)
        |=> (!ovf_lo || result[LW-1:0] == '0 || result[LW-1:0] == '1));

    assert_wide_no_high_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel[1:0] == 2'b11) |=> !ovf_hi);

    assert_acc_follows_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr |=> (acc_out == result));

    assert_acc_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_wr |=> $stable(acc_out));

endmodule

bind dual_frac_mac fmac_checker #(.DW(2*LANE_W)) u_fmac_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_sel  (op_sel),
    .sat_en  (sat_en),
    .acc_wr  (acc_wr),
    .result  (result),
    .acc_out (acc_out),
    .ovf_hi  (ovf_hi),
    .ovf_lo  (ovf_lo)
);

// File: tb/test_dual_frac_mac.sv
// Directed bench for dual_frac_mac: one task per scenario, each checking its own results.
module test_dual_frac_mac;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [2:0]  op_sel = '0;
    logic        sat_en = 1'b0;
    logic        acc_wr = 1'b0;
    logic [63:0] result;
    logic [63:0] acc_out;
    logic        ovf_hi;
    logic        ovf_lo;

    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 1'b0;
    logic [63:0] acc_exp = '0;

    always #2 clk = ~clk;

    dual_frac_mac i_dual_frac_mac (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
        .sat_en(sat_en), .acc_wr(acc_wr), .result(result), .acc_out(acc_out),
        .ovf_hi(ovf_hi), .ovf_lo(ovf_lo)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Lane model taken from R2..R6.
    task automatic lane_model(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op,
                              input logic sat, output logic [31:0] r, output logic ov);
        longint v;
        case (op[1:0])
            2'b00:   v = longint'(shortint'(a[31:16])) * longint'(shortint'(b[31:16])) * 2;
            2'b01:   v = longint'(shortint'(a[15:0])) * longint'(shortint'(b[15:0])) * 2;
            default: v = (longint'(int'(a)) * longint'(int'(b))) >>> 31;
        endcase
        if (op[2]) ov = (v < 0) || (v > 64'sd4294967295);
        else       ov = (v < -64'sd2147483648) || (v > 64'sd2147483647);
        if (ov && sat) begin
            if (op[2]) r = (v < 0) ? 32'h0000_0000 : 32'hFFFF_FFFF;
            else       r = (v < 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
        end else begin
            r = v[31:0];
        end
    endtask

    // Apply one operation, wait for the registered outputs, compare all of them.
    task automatic apply(input string req, input logic [63:0] a, input logic [63:0] b,
                         input logic [2:0] op, input logic sat, input logic accw);
        logic [63:0] er;
        logic        eh;
        logic        el;
        if (op[1:0] == 2'b11) begin
            longint p;
            p  = longint'(int'(a[31:0])) * longint'(int'(b[31:0]));
            el = (p > 64'sd4611686018427387903) || (p < -64'sd4611686018427387904);
            eh = 1'b0;
            if (el && sat) er = (p < 0) ? 64'h8000_0000_0000_0000 : 64'h7FFF_FFFF_FFFF_FFFF;
            else           er = p <<< 1;
        end else begin
            logic [31:0] rh;
            logic [31:0] rl;
            lane_model(a[63:32], b[63:32], op, sat, rh, eh);
            lane_model(a[31:0], b[31:0], op, sat, rl, el);
            er = {rh, rl};
        end
        if (accw) acc_exp = er;
        op_a = a; op_b = b; op_sel = op; sat_en = sat; acc_wr = accw;
        @(posedge clk);
        @(negedge clk);
        chk({req, " result"}, result, er);
        chk({req, " ovf_hi"}, {63'd0, ovf_hi}, {63'd0, eh});
        chk({req, " ovf_lo"}, {63'd0, ovf_lo}, {63'd0, el});
        chk({req, " acc"}, acc_out, acc_exp);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        acc_wr = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        acc_exp = '0;
        chk("R1 reset result", result, 64'd0);
        chk("R1 reset acc", acc_out, 64'd0);
        chk("R1 reset flags", {62'd0, ovf_hi, ovf_lo}, 64'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_upper_half();
        apply("R2 upper halves", 64'h4000_1234_C000_7FFF, 64'h2000_5678_6000_0003, 3'b000, 1'b0, 1'b0);
        apply("R2 upper halves mixed sign", 64'hFFFF_0001_8001_0002, 64'h7FFF_0003_0002_0004, 3'b000, 1'b1, 1'b0);
    endtask

    task automatic t_lower_half();
        apply("R3 lower halves", 64'h4000_1234_C000_7FFF, 64'h2000_5678_6000_0003, 3'b001, 1'b0, 1'b0);
        apply("R3 lower halves negative", 64'h0001_F000_0002_8001, 64'h0003_0100_0004_7FFF, 3'b001, 1'b1, 1'b0);
    endtask

    task automatic t_word();
        apply("R4 full word", 64'h4000_0000_C000_0000, 64'h4000_0000_4000_0000, 3'b010, 1'b0, 1'b0);
        apply("R4 full word odd", 64'h1234_5678_8765_4321, 64'h0FED_CBA9_7654_3210, 3'b010, 1'b0, 1'b0);
    endtask

    task automatic t_signed_sat();
        apply("R5 half min*min no sat", 64'h8000_0000_0000_8000, 64'h8000_0000_0000_8000, 3'b000, 1'b0, 1'b0);
        apply("R5 half min*min sat", 64'h8000_0000_0000_8000, 64'h8000_0000_0000_8000, 3'b000, 1'b1, 1'b0);
        apply("R5 word min*min sat", 64'h8000_0000_8000_0000, 64'h8000_0000_7FFF_FFFF, 3'b010, 1'b1, 1'b0);
        apply("R5 lower min*min sat", 64'h0000_8000_0000_8000, 64'h0000_8000_0000_1000, 3'b001, 1'b1, 1'b0);
    endtask

    task automatic t_unsigned_sat();
        apply("R6 unsigned negative no sat", 64'hC000_0000_4000_0000, 64'h4000_0000_C000_0000, 3'b110, 1'b0, 1'b0);
        apply("R6 unsigned negative sat", 64'hC000_0000_4000_0000, 64'h4000_0000_C000_0000, 3'b110, 1'b1, 1'b0);
        apply("R6 unsigned half min*min", 64'h8000_0000_FFFF_0000, 64'h8000_0000_0001_0000, 3'b100, 1'b1, 1'b0);
    endtask

    task automatic t_wide();
        apply("R7 wide plain", 64'hFFFF_FFFF_1234_5678, 64'h1111_1111_9ABC_DEF0, 3'b011, 1'b0, 1'b0);
        apply("R7 wide min*min wrap", 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, 3'b011, 1'b0, 1'b0);
        apply("R7 wide min*min sat uns bit", 64'h8000_0000_8000_0000, 64'h8000_0000_8000_0000, 3'b111, 1'b1, 1'b0);
    endtask

    task automatic t_accumulate();
        apply("R8 acc write", 64'h4000_0000_2000_0000, 64'h3000_0000_1000_0000, 3'b010, 1'b0, 1'b1);
        apply("R8 acc hold", 64'h7FFF_7FFF_7FFF_7FFF, 64'h7FFF_7FFF_7FFF_7FFF, 3'b000, 1'b0, 1'b0);
        apply("R8 acc write sat", 64'h8000_0000_0000_8000, 64'h8000_0000_0000_8000, 3'b000, 1'b1, 1'b1);
        apply("R8 acc write wide", 64'h0000_0000_0000_0003, 64'h0000_0000_FFFF_FFFF, 3'b011, 1'b0, 1'b1);
        apply("R8 acc hold again", 64'h0, 64'h0, 3'b001, 1'b0, 1'b0);
    endtask

    task automatic t_pulse();
        apply("R9 overflow cycle", 64'h8000_0000_8000_0000, 64'h8000_0000_8000_0000, 3'b000, 1'b1, 1'b0);
        apply("R9 flags drop", 64'h0100_0000_0100_0000, 64'h0100_0000_0100_0000, 3'b000, 1'b1, 1'b0);
    endtask

    task automatic t_reset_midrun();
        apply("R1 acc before reset", 64'h1000_0000_1000_0000, 64'h2000_0000_2000_0000, 3'b010, 1'b0, 1'b1);
        t_reset();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_upper_half();
        t_lower_half();
        t_word();
        t_signed_sat();
        t_unsigned_sat();
        t_wide();
        t_accumulate();
        t_pulse();
        t_reset_midrun();
        apply("R2 after reset", 64'h2000_0000_2000_0000, 64'h2000_0000_2000_0000, 3'b000, 1'b0, 1'b0);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

endmodule